// File: doc/BRIEF.md
# 8-bit Add, Subtract and Compare Unit with Status Flags

This block executes one 8-bit arithmetic instruction per clock against a 32-entry byte register file. It covers nine operations: add, add with carry, subtract, subtract with borrow, compare, and compare with borrow, all between two registers. It also covers three forms with a constant: subtract immediate, subtract immediate with borrow, and compare immediate. Each accepted instruction reads its operands and forms a 9-bit sum or difference. On the same edge it updates a six-bit status word and, except for the compare forms, writes the destination register.

A controller presents a 16-bit instruction word with a valid strobe. The unit is ready whenever it is out of reset. A read-only observation port returns any register, so the surrounding logic can consume results.

Top module: `carry_alu8`

## Requirements
- R1: A synchronous reset clears every register and every status bit to zero. `in_ready` is high in every cycle in which reset is low.
- R2: For register-to-register forms, the opcode is `instr[15:10]`: 000011 add, 000111 add with carry, 000110 subtract, 000010 subtract with borrow, 000101 compare, 000001 compare with borrow. The destination is `instr[8:4]` and the source is `{instr[9], instr[3:0]}`. Add and subtract results are written to the destination on the edge that accepts the instruction.
- R3: For constant forms, the opcode is `instr[15:12]`: 0101 subtract immediate, 0100 subtract immediate with borrow, 0011 compare immediate. The destination is register 16 + `instr[7:4]`. The constant is `{instr[11:8], instr[3:0]}`. Registers 0 to 15 are never written by these forms.
- R4: The three compare forms update the status word and leave every register unchanged.
- R5: Only add with carry, subtract with borrow, compare with borrow and subtract immediate with borrow add or subtract the current C bit. All other operations ignore it.
- R6: Status bits are `status[0]`=C, `[1]`=Z, `[2]`=N, `[3]`=V, `[4]`=S, `[5]`=H. C is bit 8 of the 9-bit sum, or the borrow for subtraction. N is bit 7 of the result.
- R7: H is bit 4 of (dest ^ src ^ result), the carry or borrow out of the low nibble. V is bit 7 of that xor, xored with C, which flags signed overflow.
- R8: S equals N xor V.
- R9: For subtract with borrow, compare with borrow and subtract immediate with borrow, Z is set only if the result is zero and Z was already set. For the other operations, Z is set exactly when the result is zero.
- R10: With `in_valid` low, or with an instruction word that matches none of the nine operations, no register and no status bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word is present this cycle |
| in_ready | output | 1 | Unit accepts an instruction this cycle |
| instr | input | 16 | Instruction word |
| obs_sel | input | 5 | Register index for the observation port |
| obs_data | output | 8 | Current contents of register `obs_sel` |
| status | output | 6 | Status word {H,S,V,N,Z,C} |

## Verification
Faults in the internal state surface at the ports one cycle after the instruction that caused them. A wrong operand, a missing carry-in or a wrongly chained Z shows up in `status` on the next cycle, and in the destination register read through `obs_data`. A compare that writes back, or a constant form that touches registers 0 to 15, corrupts a register that a later read or a later operation exposes. For this reason the bench reads the destination back after every instruction and keeps a full model of the register file. Flag corners are driven deliberately: signed overflow in both directions, nibble carry and borrow, full wrap to zero, and sticky Z with the prior Z set and clear.

// File: rtl/carry_alu8.sv
module carry_alu8 (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [15:0]      instr,
  input  logic [4:0]       obs_sel,
  output logic [7:0]       obs_data,
  output logic [5:0]       status
);
  logic [31:0][7:0] rf;
  logic [5:0]       sr;

  logic [5:0] op6;
  logic [3:0] op4;
  assign op6 = instr[15:10];
  assign op4 = instr[15:12];

  logic do_cpc, do_sbc, do_add, do_cp, do_sub, do_adc;
  logic do_cpi, do_sbci, do_subi;
  assign do_cpc  = op6 == 6'b000001;
  assign do_sbc  = op6 == 6'b000010;
  assign do_add  = op6 == 6'b000011;
  assign do_cp   = op6 == 6'b000101;
  assign do_sub  = op6 == 6'b000110;
  assign do_adc  = op6 == 6'b000111;
  assign do_cpi  = op4 == 4'b0011;
  assign do_sbci = op4 == 4'b0100;
  assign do_subi = op4 == 4'b0101;

  logic is_imm, is_sum, use_c, chain_z, no_wb, legal, fire;
  assign is_imm  = do_cpi | do_sbci | do_subi;
  assign is_sum  = do_add | do_adc;
  assign use_c   = do_adc | do_sbc | do_cpc | do_sbci;
  assign chain_z = do_sbc | do_cpc | do_sbci;
  assign no_wb   = do_cp | do_cpc | do_cpi;
  assign legal   = is_imm | do_cpc | do_sbc | do_add | do_cp | do_sub | do_adc;
  assign fire    = in_valid & legal & ~rst;

  logic [4:0] rd, rr;
  assign rd = is_imm ? {1'b1, instr[7:4]} : instr[8:4];
  assign rr = {instr[9], instr[3:0]};

  logic [7:0] opa, opb;
  logic [8:0] ci;
  assign opa = rf[rd];
  assign opb = is_imm ? {instr[11:8], instr[3:0]} : rf[rr];
  assign ci  = {8'd0, use_c & sr[0]};

  logic [8:0] res;
  assign res = is_sum ? ({1'b0, opa} + {1'b0, opb} + ci)
                      : ({1'b0, opa} - {1'b0, opb} - ci);

  logic [7:0] xv;
  assign xv = opa ^ opb ^ res[7:0];

  logic fc, fz, fn, fv, fs, fh;
  assign fc = res[8];
  assign fz = (res[7:0] == 8'd0) & (~chain_z | sr[1]);
  assign fn = res[7];
  assign fv = xv[7] ^ fc;
  assign fs = fn ^ fv;
  assign fh = xv[4];

  always_ff @(posedge clk) begin
    if (rst) begin
      rf <= '0;
      sr <= '0;
    end else if (fire) begin
      sr <= {fh, fs, fv, fn, fz, fc};
      if (!no_wb) rf[rd] <= res[7:0];
    end
  end

  assign in_ready = ~rst;
  assign obs_data = rf[obs_sel];
  assign status   = sr;
endmodule

module carry_alu8_chk (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [15:0]      instr,
  input logic [5:0]       status,
  input logic [31:0][7:0] rf
);
  logic k_cmp, k_imm, k_chain, k_known, rst_q;
  assign k_cmp   = (instr[15:10] == 6'b000001) || (instr[15:10] == 6'b000101) || (instr[15:12] == 4'b0011);
  assign k_imm   = (instr[15:12] == 4'b0011) || (instr[15:12] == 4'b0100) || (instr[15:12] == 4'b0101);
  assign k_chain = (instr[15:10] == 6'b000001) || (instr[15:10] == 6'b000010) || (instr[15:12] == 4'b0100);
  assign k_known = k_imm || (instr[15:10] == 6'b000001) || (instr[15:10] == 6'b000010) ||
                   (instr[15:10] == 6'b000011) || (instr[15:10] == 6'b000101) ||
                   (instr[15:10] == 6'b000110) || (instr[15:10] == 6'b000111);

  always_ff @(posedge clk) rst_q <= rst;

  always @(negedge clk) begin
    if (rst_q === 1'b1 && rst === 1'b1)
      assert_reset_clear_R1: assert (status == 6'd0 && rf == '0);
  end

  assert_ready_R1: assert property (@(posedge clk) disable iff (rst)
    in_ready);

  assert_cmp_no_write_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && k_cmp) |=> $stable(rf));

  assert_imm_low_regs_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && k_imm) |=> $stable(rf[15:0]));

  assert_sign_bit_R8: assert property (@(posedge clk) disable iff (rst)
    status[4] == (status[2] ^ status[3]));

  assert_sticky_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && k_chain && !status[1]) |=> !status[1]);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!in_valid || !k_known) |=> ($stable(status) && $stable(rf)));
endmodule

bind carry_alu8 carry_alu8_chk i_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .instr(instr), .status(status), .rf(rf)
);

// File: tb/test_carry_alu8.sv
module test_carry_alu8;
  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [15:0] instr = 16'd0;
  logic [4:0] obs_sel = 5'd0;
  logic in_ready;
  logic [7:0] obs_data;
  logic [5:0] status;

  int checks = 0, errors = 0;
  logic [7:0] m_rf [32];
  logic [5:0] m_sr;

  localparam int K_ADD = 0, K_ADC = 1, K_SUB = 2, K_SBC = 3, K_CP = 4,
                 K_CPC = 5, K_SUBI = 6, K_SBCI = 7, K_CPI = 8;

  always #5 clk = ~clk;

  carry_alu8 i_carry_alu8 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .instr(instr), .obs_sel(obs_sel), .obs_data(obs_data), .status(status)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int sx(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic logic [15:0] encode(int kind, int d, int s);
    logic [4:0] dd = 5'(d);
    logic [4:0] ss = 5'(s);
    logic [7:0] kk = 8'(s);
    case (kind)
      K_ADD:  return {6'b000011, ss[4], dd, ss[3:0]};
      K_ADC:  return {6'b000111, ss[4], dd, ss[3:0]};
      K_SUB:  return {6'b000110, ss[4], dd, ss[3:0]};
      K_SBC:  return {6'b000010, ss[4], dd, ss[3:0]};
      K_CP:   return {6'b000101, ss[4], dd, ss[3:0]};
      K_CPC:  return {6'b000001, ss[4], dd, ss[3:0]};
      K_SUBI: return {4'b0101, kk[7:4], dd[3:0], kk[3:0]};
      K_SBCI: return {4'b0100, kk[7:4], dd[3:0], kk[3:0]};
      default: return {4'b0011, kk[7:4], dd[3:0], kk[3:0]};
    endcase
  endfunction

  task automatic run(int kind, int d, int s, string req);
    int dv, sv, ci, full, lo, sg;
    bit imm, sub, cmp, uses, chain, c, z, n, v, h, sf;
    logic [7:0] res;
    logic [5:0] exp_sr;
    imm   = (kind == K_SUBI) || (kind == K_SBCI) || (kind == K_CPI);
    cmp   = (kind == K_CP) || (kind == K_CPC) || (kind == K_CPI);
    uses  = (kind == K_ADC) || (kind == K_SBC) || (kind == K_CPC) || (kind == K_SBCI);
    chain = (kind == K_SBC) || (kind == K_CPC) || (kind == K_SBCI);
    sub   = (kind != K_ADD) && (kind != K_ADC);
    dv = int'(m_rf[d]);
    sv = imm ? (s & 255) : int'(m_rf[s]);
    ci = uses ? int'(m_sr[0]) : 0;
    if (!sub) begin
      full = dv + sv + ci; c = full > 255;
      lo = (dv % 16) + (sv % 16) + ci; h = lo > 15;
      sg = sx(dv) + sx(sv) + ci;
    end else begin
      full = dv - sv - ci; c = full < 0;
      lo = (dv % 16) - (sv % 16) - ci; h = lo < 0;
      sg = sx(dv) - sx(sv) - ci;
    end
    res = 8'(full);
    v = (sg > 127) || (sg < -128);
    n = res[7];
    sf = n ^ v;
    z = (res == 8'd0);
    if (chain) z = z && m_sr[1];
    exp_sr = {h, sf, v, n, z, c};
    @(negedge clk);
    instr = encode(kind, d, s);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    obs_sel = 5'(d);
    #1;
    check(req, "status", int'(status), int'(exp_sr));
    if (!cmp) m_rf[d] = res;
    m_sr = exp_sr;
    check(req, "dest reg", int'(obs_data), int'(m_rf[d]));
  endtask

  task automatic set_reg(int r, int v);
    if (r >= 16) run(K_SUBI, r, (int'(m_rf[r]) - v) & 255, "R3");
    else begin
      set_reg(16, v);
      run(K_SUB, r, r, "R2");
      run(K_ADD, r, 16, "R2");
    end
  endtask

  task automatic set_c(bit cv);
    set_reg(30, cv ? 0 : 1);
    run(K_CPI, 30, 1, "R4");
  endtask

  task automatic scan_regs(string req);
    for (int r = 0; r < 32; r++) begin
      obs_sel = 5'(r);
      #1;
      check(req, "register file", int'(obs_data), int'(m_rf[r]));
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    foreach (m_rf[i]) m_rf[i] = 8'd0;
    m_sr = 6'd0;
    @(negedge clk);
    check("R1", "status after reset", int'(status), 0);
    check("R1", "in_ready", int'(in_ready), 1);
    scan_regs("R1");
  endtask

  task automatic t_add();
    set_reg(1, 8'h7F); set_reg(2, 8'h01);
    run(K_ADD, 1, 2, "R2 R6 R7 R8 add signed overflow");
    set_reg(3, 8'hFF);
    run(K_ADD, 3, 2, "R6 R7 R9 add wrap to zero");
    set_reg(31, 8'h3C); set_reg(17, 8'hC4);
    run(K_ADD, 31, 17, "R2 high register fields");
    set_reg(4, 8'h80);
    run(K_ADD, 4, 4, "R6 R7 add negative overflow");
  endtask

  task automatic t_carry_in();
    set_reg(5, 8'h10); set_reg(6, 8'h0F);
    set_c(1); run(K_ADC, 5, 6, "R5 adc with carry");
    set_c(0); run(K_ADC, 5, 6, "R5 adc without carry");
    set_c(1); run(K_ADD, 5, 6, "R5 add ignores carry");
    set_c(1); run(K_SUB, 5, 6, "R5 sub ignores carry");
    set_c(1); run(K_SUBI, 20, 8'h01, "R5 subi ignores carry");
    set_reg(7, 8'h00); set_reg(8, 8'h00);
    set_c(1); run(K_SBC, 7, 8, "R5 R6 sbc borrow in");
  endtask

  task automatic t_sub();
    set_reg(9, 8'h00); set_reg(10, 8'h01);
    run(K_SUB, 9, 10, "R6 R7 borrow out");
    set_reg(11, 8'h80);
    run(K_SUB, 11, 10, "R7 R8 sub signed overflow");
    set_reg(12, 8'h20); set_reg(13, 8'h01);
    run(K_SUB, 12, 13, "R7 nibble borrow");
  endtask

  task automatic t_immediate();
    set_reg(18, 8'h9A);
    run(K_SUBI, 18, 8'hA5, "R3 subi constant split");
    set_c(1); run(K_SBCI, 18, 8'h3C, "R3 R5 sbci");
    run(K_CPI, 18, 8'hF0, "R3 R4 cpi");
    scan_regs("R3 low registers untouched");
  endtask

  task automatic t_compare();
    set_reg(14, 8'h55); set_reg(15, 8'h55);
    run(K_CP, 14, 15, "R4 cp equal");
    set_c(1); run(K_CPC, 14, 15, "R4 R5 cpc");
    run(K_CPI, 25, 8'h7F, "R4 cpi");
    scan_regs("R4 no register written");
  endtask

  task automatic t_sticky_z();
    set_reg(21, 8'h42); set_reg(22, 8'h42);
    set_reg(23, 8'h00); set_reg(24, 8'h00);
    run(K_CP, 21, 22, "R9 set z");
    run(K_SBC, 23, 24, "R9 sbc keeps z");
    run(K_CPI, 21, 8'h00, "R9 clear z");
    run(K_CPC, 23, 24, "R9 cpc zero result z clear");
    run(K_SBCI, 24, 8'h00, "R9 sbci zero result z clear");
    run(K_CP, 21, 22, "R9 set z again");
    run(K_CPC, 21, 22, "R9 cpc keeps z");
    run(K_SUB, 21, 22, "R9 sub zero plain z");
  endtask

  task automatic idle(logic [15:0] w, logic v, string req);
    @(negedge clk);
    instr = w;
    in_valid = v;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, "status unchanged", int'(status), int'(m_sr));
    scan_regs(req);
  endtask

  task automatic t_ignore();
    set_reg(26, 8'h11); set_reg(27, 8'h22);
    idle(encode(K_ADD, 26, 27), 1'b0, "R10 valid low");
    idle(16'h0000, 1'b1, "R10 unknown opcode 000000");
    idle(16'hF3A5, 1'b1, "R10 unknown opcode 1111");
    idle(16'h2C00, 1'b1, "R10 unknown opcode 001011");
  endtask

  task automatic t_reset_again();
    set_reg(28, 8'hAA);
    set_c(1);
    t_reset();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_add();
    t_carry_in();
    t_sub();
    t_immediate();
    t_compare();
    t_sticky_z();
    t_ignore();
    t_reset_again();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule